// File: doc/BRIEF.md
# Switch-Threshold Cycle Interrupt Counter

This block counts processor bus cycles in a wide free-running counter and raises an interrupt request once the count reaches a threshold. Four configuration switches, read live from the board, choose that threshold. A single control bit from the surrounding cartridge logic drives the counter. While the bit is high, the counter is forced to zero and held there, and any pending request is cleared. While the bit is low, the counter advances once for every qualified processor cycle.

The threshold compares only the upper five bits of the count. The top bit must be one, and the next four bits must equal the switch vector. Every bit below those five is ignored. The request therefore sets on the first count that enters the matching window. It then stays set until the control bit goes high or reset is applied. The counter is 30 bits wide by default, and the window boundaries scale with the width parameter.

Top module: `cycleIrqTop`

## Requirements
- R1: While reset is high, the counter goes to zero and `irqReq` goes low, and `irqReq` stays low after reset is released until a threshold is reached.
- R2: While `ctrlHold` is low, the counter rises by exactly one on each clock edge where `cycleEn` is high, and keeps its value on edges where `cycleEn` is low.
- R3: While `ctrlHold` is high, the counter is forced to zero and does not advance, whatever `cycleEn` is. Counting then restarts from zero, so a full threshold's worth of cycles is needed again.
- R4: A clock edge with `ctrlHold` high clears a pending `irqReq`, and `irqReq` is low after that edge.
- R5: The threshold pattern needs count bit CNT_W-1 equal to 1 and bits CNT_W-2 down to CNT_W-5 equal to `dipSw[3:0]`, where `dipSw[3]` is the most significant. All lower count bits are ignored. `irqReq` goes high on the clock edge that follows the first cycle where the count matches the pattern.
- R6: With the 30-bit default, the threshold is 0x20000000 for `dipSw`=0000, 0x3E000000 for `dipSw`=1111, and 0x28000000 for `dipSw`=0100. In general the threshold is 2^(CNT_W-1) + `dipSw`·2^(CNT_W-5).
- R7: Once high, `irqReq` stays high while `ctrlHold` is low, including after the count leaves the matching window.
- R8: `dipSw` is compared live on every cycle. Changing it while counting moves the threshold at once, so the request sets on the edge after the current count falls into the new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycleEn | input | 1 | Qualifies a processor cycle for counting |
| ctrlHold | input | 1 | Control bit: 1 holds the counter at zero and acknowledges the request; 0 lets it count |
| dipSw | input | 4 | Threshold switches, bit 3 most significant |
| irqReq | output | 1 | Latched interrupt request, active high |

## Verification
The bound checker watches the counter on every cycle. It checks the single-step increment, the stall while `cycleEn` is low, the forced zero and the acknowledge while `ctrlHold` is high, the latching of the request, and that every rising edge of the request follows a count that was inside the window. The exact cycle at which the request appears can only be shown by the bench scenarios. These cover each switch setting, a threshold lowered while counting, a restart after a hold, and gapped enables. The bench runs a reduced counter width so that the thresholds can be reached.

// File: rtl/cycle_irq_pkg.sv
package cycle_irq_pkg;

  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic clrCnt;   // force counter to zero
    logic incCnt;   // advance counter by one
  } cntStrobes_t;

endpackage

// File: rtl/cycleIrqCount.sv
module cycleIrqCount
  import cycle_irq_pkg::*;
#(
  parameter int CNT_W = 30,
  parameter int SW_W  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  cntStrobes_t     strobes,
  input  logic [SW_W-1:0] dipSw,
  output logic [CNT_W-1:0] cntVal,
  output logic            inWindow
);

  localparam int CmpW = SW_W + 1;
  localparam int LowW = CNT_W - CmpW;

  logic [CNT_W-1:0] cntQ;
  logic [CmpW-1:0]  pattern;
  logic [CmpW-1:0]  bitHit;

  always_ff @(posedge clk) begin
    if (rst || strobes.clrCnt) begin
      cntQ <= '0;
    end else if (strobes.incCnt) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign pattern = {1'b1, dipSw};

  // Per-bit equality over the upper compare field; low bits ignored.
  for (genvar gi = 0; gi < CmpW; gi++) begin : g_cmp
    assign bitHit[gi] = ~(cntQ[LowW + gi] ^ pattern[gi]);
  end

  assign inWindow = &bitHit;
  assign cntVal   = cntQ;

endmodule

// File: rtl/cycleIrqCtrl.sv
module cycleIrqCtrl
  import cycle_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cycleEn,
  input  logic        ctrlHold,
  input  logic        inWindow,
  output cntStrobes_t strobes,
  output logic        irqReq
);

  logic irqQ;
  logic setIrq;

  always_comb begin
    strobes.clrCnt = ctrlHold;
    strobes.incCnt = ~ctrlHold & cycleEn;
    setIrq         = ~ctrlHold & inWindow;
  end

  always_ff @(posedge clk) begin
    if (rst || ctrlHold) begin
      irqQ <= 1'b0;
    end else if (setIrq) begin
      irqQ <= 1'b1;
    end
  end

  assign irqReq = irqQ;

endmodule

// File: rtl/cycleIrqTop.sv
module cycleIrqTop
  import cycle_irq_pkg::*;
#(
  parameter int CNT_W = 30,
  parameter int SW_W  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cycleEn,
  input  logic            ctrlHold,
  input  logic [SW_W-1:0] dipSw,
  output logic            irqReq
);

  cntStrobes_t      strobes;
  logic [CNT_W-1:0] cntVal;
  logic             inWindow;

  cycleIrqCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cycleEn  (cycleEn),
    .ctrlHold (ctrlHold),
    .inWindow (inWindow),
    .strobes  (strobes),
    .irqReq   (irqReq)
  );

  cycleIrqCount #(.CNT_W(CNT_W), .SW_W(SW_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dipSw    (dipSw),
    .cntVal   (cntVal),
    .inWindow (inWindow)
  );

endmodule

// File: rtl/cycleIrqChk.sv
module cycleIrqChk #(
  parameter int CNT_W = 30,
  parameter int SW_W  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cycleEn,
  input logic            ctrlHold,
  input logic [SW_W-1:0] dipSw,
  input logic            irqReq,
  input logic [CNT_W-1:0] cntVal
);

  localparam int LowW = CNT_W - SW_W - 1;

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctrlHold |=> cntVal == '0); // R3

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ctrlHold |=> !irqReq); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctrlHold && cycleEn) |=> cntVal == $past(cntVal) + 1'b1); // R2

  AST_COUNT_STALL: assert property (@(posedge clk) disable iff (rst)
    (!ctrlHold && !cycleEn) |=> $stable(cntVal)); // R2

  AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (rst)
    (irqReq && !ctrlHold) |=> irqReq); // R7

  AST_IRQ_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(irqReq) |-> ($past(cntVal[CNT_W-1:LowW]) == {1'b1, $past(dipSw)})); // R5

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!irqReq && cntVal == '0)); // R1

endmodule

bind cycleIrqTop cycleIrqChk #(.CNT_W(CNT_W), .SW_W(SW_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cycleEn  (cycleEn),
  .ctrlHold (ctrlHold),
  .dipSw    (dipSw),
  .irqReq   (irqReq),
  .cntVal   (cntVal)
);

// File: tb/cycleIrqTop_tb.sv
`timescale 1ns/1ps
module cycleIrqTop_tb;

  localparam int CntW = 12;
  localparam int SwW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cycleEn = 1'b0;
  logic ctrlHold = 1'b0;
  logic [SwW-1:0] dipSw = '0;
  logic irqReq;

  int errCnt = 0;
  int chkCnt = 0;
  logic done = 1'b0;

  logic [CntW-1:0] mCnt = '0;
  logic            mIrq = 1'b0;

  always #4 clk = ~clk;

  cycleIrqTop #(.CNT_W(CntW), .SW_W(SwW)) u_dut (
    .clk(clk), .rst(rst), .cycleEn(cycleEn), .ctrlHold(ctrlHold),
    .dipSw(dipSw), .irqReq(irqReq)
  );

  // Threshold from R6 formula, scaled to the bench width.
  function automatic int thr(input logic [SwW-1:0] sw);
    return (1 << (CntW-1)) + (int'(sw) << (CntW-5));
  endfunction

  function automatic logic inWin(input logic [CntW-1:0] c, input logic [SwW-1:0] sw);
    return c[CntW-1:CntW-5] == {1'b1, sw};
  endfunction

  task automatic check(input logic exp, input string tag);
    chkCnt++;
    if (irqReq !== exp) begin
      errCnt++;
      $display("FAIL %s: irqReq actual=%0b expected=%0b at %0t", tag, irqReq, exp, $time);
    end
  endtask

  // Apply inputs for one edge, update model, compare at the next falling edge.
  task automatic step(input logic en, input logic hold, input logic [SwW-1:0] sw, input string tag);
    cycleEn = en; ctrlHold = hold; dipSw = sw;
    if (hold) begin
      mCnt = '0; mIrq = 1'b0;
    end else begin
      if (inWin(mCnt, sw)) mIrq = 1'b1;
      if (en) mCnt = mCnt + 1'b1;
    end
    @(negedge clk);
    check(mIrq, tag);
  endtask

  task automatic run(input int n, input logic en, input logic [SwW-1:0] sw, input string tag);
    for (int i = 0; i < n; i++) step(en, 1'b0, sw, tag);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(1'b0, "R1 reset");
    rst = 1'b0;
    mCnt = '0; mIrq = 1'b0;
    run(10, 1'b1, 4'b0000, "R1 after reset");

    // R6 all switches open
    step(1'b1, 1'b1, 4'b0000, "R4 clear");
    run(thr(4'b0000), 1'b1, 4'b0000, "R6 open before");
    check(1'b0, "R6 open one short");
    step(1'b1, 1'b0, 4'b0000, "R6 open fire");
    check(1'b1, "R6 open threshold 2^(W-1)");

    // R7 stays high past the window
    run(200, 1'b1, 4'b0000, "R7 latched");
    check(1'b1, "R7 beyond window");

    // R4 acknowledge
    step(1'b0, 1'b1, 4'b0000, "R4 ack");
    check(1'b0, "R4 ack clears");

    // R3 hold with enable, then full restart; R6 only C closed
    for (int i = 0; i < 50; i++) step(1'b1, 1'b1, 4'b0100, "R3 hold");
    run(thr(4'b0100), 1'b1, 4'b0100, "R3 restart");
    check(1'b0, "R3/R6 C-only one short");
    step(1'b1, 1'b0, 4'b0100, "R6 C-only fire");
    check(1'b1, "R6 C-only threshold");

    // R6 all closed, R2 with enable gaps
    step(1'b0, 1'b1, 4'b1111, "R4 clear");
    for (int i = 0; i < thr(4'b1111); i++) begin
      step(1'b0, 1'b0, 4'b1111, "R2 stall");
      step(1'b1, 1'b0, 4'b1111, "R2 step");
    end
    check(1'b0, "R2/R6 closed one short");
    step(1'b0, 1'b0, 4'b1111, "R6 closed fire");
    check(1'b1, "R6 closed threshold");

    // R8 lower the threshold mid-count
    step(1'b1, 1'b1, 4'b1111, "R4 clear");
    run(2600, 1'b1, 4'b1111, "R8 below high thr");
    check(1'b0, "R8 not yet");
    step(1'b0, 1'b0, 4'b0100, "R8 new window");
    check(1'b1, "R8 live switch change");

    // Constrained random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 40000; i++) begin
      logic en, hold;
      logic [SwW-1:0] sw;
      en   = ($urandom % 8) != 0;
      hold = ($urandom % 3000) == 0;
      sw   = dipSw;
      if (($urandom % 1500) == 0) sw = SwW'($urandom);
      step(en, hold, sw, "R5 random");
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errCnt++; chkCnt++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule